// File: doc/BRIEF.md
# Paired Timestamp Capture Unit

This block latches a free-running timer value into four capture slots when external event strobes arrive. The slots form two pairs: slots 0 and 1 (lower pair) and slots 2 and 3 (upper pair). Within a pair, a new sample always lands in the odd (newer) slot. Whatever that slot held before moves down into the even (older) slot. Every slot has a full flag. The flag is set when the slot is written and dropped when the slot is read. In flag-gated operation, a pair whose two slots are both full refuses further samples. In continuous operation, samples are always taken, and the oldest unread value is lost.

A routing input decides which event feeds which pair. A 2-bit policy field decides when a capture should also restart the external timer; this is reported on a one-cycle pulse output. Two read paths exist. The indexed port returns any slot. The pointer port returns the slot that a scan pointer currently selects, together with that pointer. In extended mode, a pointer read also drops the flag of the selected slot, and of no other slot.

Top module: `tscap_unit`

## Requirements
- R1: After a synchronous reset, every slot is empty and holds zero, the read outputs are zero, the returned pointer is 0 and `timer_clr` is low.
- R2: With `cfg_route`=0, `evt0` captures into the lower pair (slots 0,1) and `evt1` into the upper pair (slots 2,3).
- R3: With `cfg_route`=1, `evt1` captures into both pairs at once and `evt0` has no effect.
- R4: A capture writes the timer value into the odd slot of its pair and sets its flag. If that odd slot was full, its old value first moves into the even slot, which then becomes full.
- R5: With `cfg_cont`=0, an event for a pair whose two slots are both full is discarded, and the stored values stay unchanged.
- R6: With `cfg_cont`=1, every event captures. The even slot takes the previous odd value even when the even slot is still unread.
- R7: An indexed read (`rd_en`, `rd_idx`) returns the slot's value and flag on the next cycle and empties that slot. A capture into the same slot in the same cycle wins: the capture sees the slot as empty, and the slot ends full with the new value.
- R8: With `cfg_route`=0, `cfg_clr_sel` selects when `timer_clr` pulses, one cycle after a capture: code 0 never, code 1 on upper-pair captures, code 2 on lower-pair captures, code 3 on any capture.
- R9: With `cfg_route`=1, codes 1 and 2 pulse `timer_clr` on every capture.
- R10: `timer_clr` pulses only when a slot was actually written. A discarded event gives no pulse.
- R11: A pointer read (`ext_rd_en`) returns the value, flag and index of the pointed slot on the next cycle. It empties that slot only when `cfg_ext`=1.
- R12: The pointer stays on its slot while that slot is full. When that slot empties, the pointer moves to the first full slot in ascending circular index order after it. If no slot is full, it stays where it is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| timer_val | input | TW | Timer value to be captured |
| evt0 | input | 1 | Capture event strobe 0 |
| evt1 | input | 1 | Capture event strobe 1 |
| cfg_route | input | 1 | 0: evt0 to lower pair, evt1 to upper pair; 1: evt1 to both pairs |
| cfg_cont | input | 1 | 1: capture ignores full flags |
| cfg_clr_sel | input | 2 | Timer-clear policy code |
| cfg_ext | input | 1 | 1: pointer reads empty the pointed slot |
| rd_en | input | 1 | Indexed read strobe |
| rd_idx | input | 2 | Slot index for the indexed read |
| ext_rd_en | input | 1 | Pointer read strobe |
| rd_data | output | TW | Value returned by the indexed read |
| rd_full | output | 1 | Flag of the slot at the time of the indexed read |
| ext_data | output | TW | Value returned by the pointer read |
| ext_ptr | output | 2 | Index of the slot returned by the pointer read |
| ext_full | output | 1 | Flag of that slot at the time of the pointer read |
| timer_clr | output | 1 | One-cycle pulse requesting a timer restart |

## Verification
A wrong flag is seen on the very next read of that slot: `rd_full` or `ext_full` is wrong one cycle after the strobe, or a later sample is dropped or accepted when it should not be. A wrong shift shows as a swapped or stale value in the even slot when that slot is read. A wrong pointer appears as an unexpected `ext_ptr` on the next pointer read. Policy decoding errors show as a `timer_clr` pulse missing or extra in the cycle right after the capture.

// File: rtl/tscap_pkg.sv
package tscap_pkg;
  localparam int PAIRS = 2;
  localparam int SLOTS = 2 * PAIRS;
  localparam int IDXW  = $clog2(SLOTS);

  typedef enum logic [1:0] {
    CLR_NONE  = 2'd0,
    CLR_UPPER = 2'd1,
    CLR_LOWER = 2'd2,
    CLR_ANY   = 2'd3
  } clr_sel_e;
endpackage

// File: rtl/tscap_pair.sv
module tscap_pair #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cont,
  input  logic          evt,
  input  logic [TW-1:0] tval,
  input  logic          drop_lo,
  input  logic          drop_hi,
  output logic [TW-1:0] lo_q,
  output logic [TW-1:0] hi_q,
  output logic          lo_full,
  output logic          hi_full,
  output logic          lo_full_d,
  output logic          hi_full_d,
  output logic          take
);
  logic lo_avl, hi_avl, shift;

  // flags as seen after this cycle's reads
  always_comb begin
    lo_avl    = lo_full & ~drop_lo;
    hi_avl    = hi_full & ~drop_hi;
    take      = evt & (cont | ~(lo_avl & hi_avl));
    shift     = take & hi_avl;
    lo_full_d = shift | lo_avl;
    hi_full_d = take | hi_avl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= '0;
      hi_q    <= '0;
      lo_full <= 1'b0;
      hi_full <= 1'b0;
    end else begin
      lo_full <= lo_full_d;
      hi_full <= hi_full_d;
      if (take)  hi_q <= tval;
      if (shift) lo_q <= hi_q;
    end
  end
endmodule

// File: rtl/tscap_vptr.sv
module tscap_vptr
  import tscap_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [SLOTS-1:0] full_d,
  output logic [IDXW-1:0] ptr_q
);
  logic [IDXW-1:0] ptr_d;
  logic [IDXW-1:0] cand;
  logic            found;

  always_comb begin
    ptr_d = ptr_q;
    found = 1'b0;
    cand  = '0;
    if (!full_d[ptr_q]) begin
      for (int k = 1; k < SLOTS; k++) begin
        cand = IDXW'((int'(ptr_q) + k) % SLOTS);
        if (full_d[cand] && !found) begin
          ptr_d = cand;
          found = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else     ptr_q <= ptr_d;
  end
endmodule

// File: rtl/tscap_unit.sv
module tscap_unit
  import tscap_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TW-1:0]   timer_val,
  input  logic            evt0,
  input  logic            evt1,
  input  logic            cfg_route,
  input  logic            cfg_cont,
  input  logic [1:0]      cfg_clr_sel,
  input  logic            cfg_ext,
  input  logic            rd_en,
  input  logic [IDXW-1:0] rd_idx,
  input  logic            ext_rd_en,
  output logic [TW-1:0]   rd_data,
  output logic            rd_full,
  output logic [TW-1:0]   ext_data,
  output logic [IDXW-1:0] ext_ptr,
  output logic            ext_full,
  output logic            timer_clr
);
  logic [TW-1:0]    slot_q [SLOTS];
  logic [SLOTS-1:0] full_q;
  logic [SLOTS-1:0] full_d;
  logic [SLOTS-1:0] drop;
  logic [PAIRS-1:0] take;
  logic [IDXW-1:0]  vptr;
  logic             clr_d;

  always_comb begin
    drop = '0;
    if (rd_en)               drop[rd_idx] = 1'b1;
    if (ext_rd_en && cfg_ext) drop[vptr]  = 1'b1;
  end

  for (genvar g = 0; g < PAIRS; g++) begin : g_pair
    logic pair_evt;
    if (g == 0) begin : g_lower
      assign pair_evt = cfg_route ? evt1 : evt0;
    end else begin : g_upper
      assign pair_evt = evt1;
    end

    tscap_pair #(.TW(TW)) u_pair (
      .clk       (clk),
      .rst       (rst),
      .cont      (cfg_cont),
      .evt       (pair_evt),
      .tval      (timer_val),
      .drop_lo   (drop[2*g]),
      .drop_hi   (drop[2*g+1]),
      .lo_q      (slot_q[2*g]),
      .hi_q      (slot_q[2*g+1]),
      .lo_full   (full_q[2*g]),
      .hi_full   (full_q[2*g+1]),
      .lo_full_d (full_d[2*g]),
      .hi_full_d (full_d[2*g+1]),
      .take      (take[g])
    );
  end

  tscap_vptr u_vptr (
    .clk    (clk),
    .rst    (rst),
    .full_d (full_d),
    .ptr_q  (vptr)
  );

  always_comb begin
    unique case (clr_sel_e'(cfg_clr_sel))
      CLR_NONE:  clr_d = 1'b0;
      CLR_UPPER: clr_d = cfg_route ? (|take) : take[1];
      CLR_LOWER: clr_d = cfg_route ? (|take) : take[0];
      default:   clr_d = |take;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data   <= '0;
      rd_full   <= 1'b0;
      ext_data  <= '0;
      ext_ptr   <= '0;
      ext_full  <= 1'b0;
      timer_clr <= 1'b0;
    end else begin
      timer_clr <= clr_d;
      if (rd_en) begin
        rd_data <= slot_q[rd_idx];
        rd_full <= full_q[rd_idx];
      end
      if (ext_rd_en) begin
        ext_data <= slot_q[vptr];
        ext_ptr  <= vptr;
        ext_full <= full_q[vptr];
      end
    end
  end
endmodule

// File: rtl/tscap_unit_chk.sv
module tscap_unit_chk
  import tscap_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             evt0,
  input logic             evt1,
  input logic             cfg_ext,
  input logic [1:0]       cfg_clr_sel,
  input logic             rd_en,
  input logic [IDXW-1:0]  rd_idx,
  input logic             ext_rd_en,
  input logic             timer_clr,
  input logic [SLOTS-1:0] full,
  input logic [IDXW-1:0]  vptr
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (full == '0 && !timer_clr));

  assert_rd_empties_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !evt0 && !evt1) |=> !full[$past(rd_idx)]);

  assert_policy_none_R8: assert property (@(posedge clk) disable iff (rst)
    ($past(cfg_clr_sel) == 2'd0) |-> !timer_clr);

  assert_clr_needs_event_R10: assert property (@(posedge clk) disable iff (rst)
    timer_clr |-> $past(evt0 || evt1));

  assert_ext_empties_R11: assert property (@(posedge clk) disable iff (rst)
    (ext_rd_en && cfg_ext && !rd_en && !evt0 && !evt1) |=> !full[$past(vptr)]);

  assert_ptr_on_full_R12: assert property (@(posedge clk) disable iff (rst)
    (|full) |-> full[vptr]);

  assert_ptr_holds_R12: assert property (@(posedge clk) disable iff (rst)
    full[vptr] |=> (!full[$past(vptr)] || $stable(vptr)));
endmodule

bind tscap_unit tscap_unit_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .evt0        (evt0),
  .evt1        (evt1),
  .cfg_ext     (cfg_ext),
  .cfg_clr_sel (cfg_clr_sel),
  .rd_en       (rd_en),
  .rd_idx      (rd_idx),
  .ext_rd_en   (ext_rd_en),
  .timer_clr   (timer_clr),
  .full        (full_q),
  .vptr        (vptr)
);

// File: tb/tscap_unit_bench.sv
module tscap_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] timer_val = '0;
  logic          evt0 = 1'b0, evt1 = 1'b0;
  logic          cfg_route = 1'b0, cfg_cont = 1'b0, cfg_ext = 1'b0;
  logic [1:0]    cfg_clr_sel = 2'd0;
  logic          rd_en = 1'b0, ext_rd_en = 1'b0;
  logic [1:0]    rd_idx = 2'd0;
  logic [TW-1:0] rd_data, ext_data;
  logic          rd_full, ext_full, timer_clr;
  logic [1:0]    ext_ptr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tscap_unit #(.TW(TW)) u_tscap_unit (
    .clk(clk), .rst(rst), .timer_val(timer_val), .evt0(evt0), .evt1(evt1),
    .cfg_route(cfg_route), .cfg_cont(cfg_cont), .cfg_clr_sel(cfg_clr_sel),
    .cfg_ext(cfg_ext), .rd_en(rd_en), .rd_idx(rd_idx), .ext_rd_en(ext_rd_en),
    .rd_data(rd_data), .rd_full(rd_full), .ext_data(ext_data),
    .ext_ptr(ext_ptr), .ext_full(ext_full), .timer_clr(timer_clr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cap(input logic e0, input logic e1, input logic [TW-1:0] tv);
    evt0 = e0; evt1 = e1; timer_val = tv;
    @(negedge clk);
    evt0 = 1'b0; evt1 = 1'b0;
  endtask

  task automatic rd(input int idx, input int exp_d, input int exp_f, input string req);
    rd_en = 1'b1; rd_idx = 2'(idx);
    @(negedge clk);
    rd_en = 1'b0;
    chk({req, " rd_data"}, int'(rd_data), exp_d);
    chk({req, " rd_full"}, int'(rd_full), exp_f);
  endtask

  task automatic ext(input int exp_p, input int exp_d, input int exp_f, input string req);
    ext_rd_en = 1'b1;
    @(negedge clk);
    ext_rd_en = 1'b0;
    chk({req, " ext_ptr"}, int'(ext_ptr), exp_p);
    chk({req, " ext_data"}, int'(ext_data), exp_d);
    chk({req, " ext_full"}, int'(ext_full), exp_f);
  endtask

  task automatic set_cfg(input logic route, input logic cont, input logic [1:0] cs, input logic ex);
    cfg_route = route; cfg_cont = cont; cfg_clr_sel = cs; cfg_ext = ex;
  endtask

  task automatic t_reset();
    set_cfg(0, 0, 0, 0);
    do_reset();
    chk("R1 rd_data", int'(rd_data), 0);
    chk("R1 ext_ptr", int'(ext_ptr), 0);
    chk("R1 timer_clr", int'(timer_clr), 0);
    for (int i = 0; i < 4; i++) rd(i, 0, 0, "R1");
  endtask

  task automatic t_route0();
    set_cfg(0, 0, 0, 0);
    do_reset();
    cap(1, 0, 16'h0011);
    cap(0, 1, 16'h0022);
    rd(1, 'h11, 1, "R2");
    rd(0, 0, 0, "R2");
    rd(3, 'h22, 1, "R2");
    rd(2, 0, 0, "R2");
    rd(1, 'h11, 0, "R7 flag emptied");
  endtask

  task automatic t_gated();
    set_cfg(0, 0, 2'd3, 0);
    do_reset();
    cap(1, 0, 16'h00A1);
    chk("R8 code3 pulse", int'(timer_clr), 1);
    @(negedge clk);
    chk("R8 pulse one cycle", int'(timer_clr), 0);
    cap(1, 0, 16'h00A2);
    cap(1, 0, 16'h00A3);
    chk("R10 discard no pulse", int'(timer_clr), 0);
    rd(0, 'hA1, 1, "R4 shifted older");
    rd(1, 'hA2, 1, "R5 kept newer");
  endtask

  task automatic t_cont();
    set_cfg(0, 1, 0, 0);
    do_reset();
    cap(1, 0, 16'h00B1);
    cap(1, 0, 16'h00B2);
    cap(1, 0, 16'h00B3);
    rd(0, 'hB2, 1, "R6 even overwritten");
    rd(1, 'hB3, 1, "R6 odd newest");
  endtask

  task automatic t_route1();
    set_cfg(1, 0, 0, 0);
    do_reset();
    cap(0, 1, 16'h00C1);
    cap(1, 0, 16'h00C9);
    rd(1, 'hC1, 1, "R3 lower pair");
    rd(3, 'hC1, 1, "R3 upper pair");
    rd(0, 0, 0, "R3 evt0 ignored");
    rd(2, 0, 0, "R3 upper even empty");
  endtask

  task automatic t_policy();
    set_cfg(0, 1, 2'd1, 0);
    do_reset();
    cap(1, 0, 16'h0001);
    chk("R8 code1 lower", int'(timer_clr), 0);
    cap(0, 1, 16'h0002);
    chk("R8 code1 upper", int'(timer_clr), 1);
    cfg_clr_sel = 2'd2;
    cap(1, 0, 16'h0003);
    chk("R8 code2 lower", int'(timer_clr), 1);
    cap(0, 1, 16'h0004);
    chk("R8 code2 upper", int'(timer_clr), 0);
    cfg_clr_sel = 2'd0;
    cap(1, 1, 16'h0005);
    chk("R8 code0", int'(timer_clr), 0);
    cfg_route = 1'b1; cfg_clr_sel = 2'd1;
    cap(0, 1, 16'h0006);
    chk("R9 code1 routed", int'(timer_clr), 1);
    cfg_clr_sel = 2'd2;
    cap(0, 1, 16'h0007);
    chk("R9 code2 routed", int'(timer_clr), 1);
  endtask

  task automatic t_ext_mode();
    set_cfg(0, 0, 0, 1);
    do_reset();
    cap(0, 1, 16'h0031);
    ext(3, 'h31, 1, "R11 first");
    rd(3, 'h31, 0, "R11 ext emptied");
    cap(1, 0, 16'h0041);
    cap(0, 1, 16'h0032);
    ext(1, 'h41, 1, "R12 ptr moved to 1");
    ext(3, 'h32, 1, "R12 ptr next full");
    ext(3, 'h32, 0, "R12 ptr holds when empty");
    rd(1, 'h41, 0, "R11 only pointed slot");
  endtask

  task automatic t_ext_normal();
    set_cfg(0, 0, 0, 0);
    do_reset();
    cap(1, 0, 16'h0051);
    ext(1, 'h51, 1, "R11 normal");
    ext(1, 'h51, 1, "R11 normal keeps flag");
    rd(1, 'h51, 1, "R11 flag intact");
  endtask

  task automatic t_collide();
    set_cfg(0, 0, 0, 0);
    do_reset();
    cap(1, 0, 16'h0061);
    rd_en = 1'b1; rd_idx = 2'd1; evt0 = 1'b1; timer_val = 16'h0062;
    @(negedge clk);
    rd_en = 1'b0; evt0 = 1'b0;
    chk("R7 collide rd_data", int'(rd_data), 'h61);
    chk("R7 collide rd_full", int'(rd_full), 1);
    rd(1, 'h62, 1, "R7 capture wins");
    rd(0, 0, 0, "R7 no shift");
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_route0();
    t_gated();
    t_cont();
    t_route1();
    t_policy();
    t_ext_mode();
    t_ext_normal();
    t_collide();
    finish_run();
  end
endmodule